// File: doc/BRIEF.md
# Instrument Status Reporting Registers

This block keeps the status registers of a programmable instrument. Eight condition inputs feed a standard event register. Each bit sets on a one-cycle pulse and stays set until software collects it. An event enable register selects which of those bits count toward an event summary.

The event summary, a flag that says the output queue holds data, and a service-request summary bit make up a status byte. The status byte is not stored: it is rebuilt every cycle from the current register contents and the queue flag. A service-request enable register selects which status byte bits drive the service-request summary.

Software reaches the registers through a small address/strobe bus. Three command strobes act on the registers: clear-status, reset and device-clear.

Top module: `instr_status_unit`

## Requirements
- R1: An event bit becomes 1 on the clock edge after its `evt_pulse` bit is 1. It then stays 1 whatever the pulse input does, until a clear from R2 or R3.
- R2: A read strobe at address 0 (event register) presents the register contents from before the clear on `bus_rdata` one cycle later. The same edge clears the register. A pulse arriving in the strobe cycle is still set after the clear.
- R3: `clr_status` clears the event register on the next edge, keeping any pulse from the same cycle. It leaves both enable registers unchanged.
- R4: `cmd_reset` and `dev_clear` leave the event register unchanged. `cmd_reset` zeroes both enable registers and takes priority over a write in the same cycle. `dev_clear` has no effect on any register.
- R5: The event enable register (address 1) and the service-request enable register (address 3) take `bus_wdata` on a write strobe. They return their value on a read, and a read leaves them unchanged.
- R6: Status byte bits 0 to 3 and bit 7 are always 0.
- R7: Status byte bit 4 equals `queue_not_empty` in the same cycle, with no storage.
- R8: Status byte bit 5 is the OR of the event bits whose event-enable bits are 1. It falls in the cycle after the clear edge.
- R9: Status byte bit 6 is the OR of status byte bits 0-5 and 7, each ANDed with the matching service-request enable bit. Enable bit 6 has no effect.
- R10: A read at address 2 returns the status byte as it stood in the strobe cycle. Writes to addresses 0 and 2 change nothing.
- R11: After `rst_n` is low for a clock edge, all registers and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 8 | Condition pulses, one per event bit |
| queue_not_empty | input | 1 | Output queue holds data |
| bus_addr | input | 2 | Register address: 0 event, 1 event enable, 2 status byte, 3 service-request enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one cycle after the read strobe |
| clr_status | input | 1 | Clear-status command strobe |
| cmd_reset | input | 1 | Reset command strobe |
| dev_clear | input | 1 | Device-clear strobe |
| status_byte | output | 8 | Live status byte |

## Verification
The status byte is combinational, so its value is due in the same cycle as the register state or queue flag it depends on. After any edge that changes the registers, it reflects the new contents straight away.

Register state and `bus_rdata` change on the rising edge that follows their strobe. The bench drives every input on the falling edge and samples one time unit after the next rising edge. At that point it compares read data with the value its model held before the edge, and compares the status byte with the model after the edge.

// File: rtl/instr_status_pkg.sv
// Shared constants and the register address map of the status unit.
package instr_status_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // Register addresses; the bench and software depend on these values.
    typedef enum logic [ADDR_W-1:0] {
        ADR_EVENT  = 2'd0,
        ADR_EVT_EN = 2'd1,
        ADR_STATUS = 2'd2,
        ADR_SRQ_EN = 2'd3
    } reg_addr_e;

    // Status byte bit positions.
    localparam int MAV_BIT = 4;
    localparam int ESB_BIT = 5;
    localparam int MSS_BIT = 6;
endpackage

// File: rtl/stat_rw_reg.sv
// Plain read/write register with a synchronous zeroing strobe.
// Assumes: zero_req has priority over a write in the same cycle.
module stat_rw_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         zero_req,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Hold value, zero on request, else load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (zero_req) q <= '0;
        else if (we)       q <= wdata;
    end
endmodule

// File: rtl/stat_event_grp.sv
// One event group: sticky event bits, their enable register and the
// enabled summary. Assumes: clr is a single-cycle strobe; a pulse seen
// in the clear cycle survives the clear.
module stat_event_grp #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse,
    input  logic         clr,
    input  logic         en_zero,
    input  logic         en_we,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] en_q,
    output logic         summary
);
    // Latch incoming pulses; a clear drops only the older bits.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~{W{clr}}) | pulse;
    end

    stat_rw_reg #(.W(W)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_req (en_zero),
        .we       (en_we),
        .wdata    (en_wdata),
        .q        (en_q)
    );

    // OR of the enabled event bits.
    always_comb summary = |(evt_q & en_en_mask(en_q));

    function automatic logic [W-1:0] en_en_mask(input logic [W-1:0] m);
        return m;
    endfunction
endmodule

// File: rtl/stat_byte_build.sv
// Builds the unlatched status byte from the queue flag, the event
// summary and the service-request enable. Assumes: every other bit is
// reserved and reads 0; the master-summary bit never feeds itself.
module stat_byte_build #(
    parameter int W       = 8,
    parameter int MAV_POS = 4,
    parameter int ESB_POS = 5,
    parameter int MSS_POS = 6
) (
    input  logic         mav,
    input  logic         esb,
    input  logic [W-1:0] srq_en,
    output logic [W-1:0] sbyte
);
    logic [W-1:0] base;
    logic [W-1:0] req;

    // Place the summaries, mask by enable, fold into the master bit.
    always_comb begin
        base          = '0;
        base[MAV_POS] = mav;
        base[ESB_POS] = esb;
        req           = base & srq_en;
        req[MSS_POS]  = 1'b0;
        sbyte         = base;
        sbyte[MSS_POS] = |req;
    end
endmodule

// File: rtl/stat_bus_port.sv
// Address decode and registered read mux for the status registers.
// Assumes: one strobe of each kind per cycle; read data is the value
// before any clear-on-read and holds until the next read.
module stat_bus_port
    import instr_status_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [W-1:0]  evt_q,
    input  logic [W-1:0]  evt_en_q,
    input  logic [W-1:0]  sbyte,
    input  logic [W-1:0]  srq_en_q,
    output logic          evt_rd_clr,
    output logic          evt_en_we,
    output logic          srq_en_we,
    output logic [W-1:0]  rdata
);
    reg_addr_e    sel;
    logic [W-1:0] mux;

    // Decode strobes per address; writes to read-only addresses vanish.
    always_comb begin
        sel        = reg_addr_e'(addr);
        evt_rd_clr = rd && (sel == ADR_EVENT);
        evt_en_we  = wr && (sel == ADR_EVT_EN);
        srq_en_we  = wr && (sel == ADR_SRQ_EN);
    end

    // Select the addressed register's present value.
    always_comb begin
        unique case (sel)
            ADR_EVENT:  mux = evt_q;
            ADR_EVT_EN: mux = evt_en_q;
            ADR_STATUS: mux = sbyte;
            ADR_SRQ_EN: mux = srq_en_q;
            default:    mux = '0;
        endcase
    end

    // Capture read data one edge after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= mux;
    end
endmodule

// File: rtl/instr_status_unit.sv
// Status reporting unit: standard event group, service-request enable
// and live status byte behind a small register bus. Assumes strobes
// are synchronous to clk. Reset command zeroes only enable registers;
// device clear is accepted and has no effect on these registers.
module instr_status_unit
    import instr_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  evt_pulse,
    input  logic              queue_not_empty,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              clr_status,
    input  logic              cmd_reset,
    input  logic              dev_clear,
    output logic [REG_W-1:0]  status_byte
);
    logic [REG_W-1:0] evt_q;
    logic [REG_W-1:0] ese_q;
    logic [REG_W-1:0] sre_q;
    logic             esb;
    logic             evt_rd_clr;
    logic             ese_we;
    logic             sre_we;
    logic             evt_clr;
    logic             dev_clear_seen;

    // Combine the two ways the event register is cleared.
    always_comb evt_clr = clr_status | evt_rd_clr;

    // Device clear is accepted but acts on nothing in this block.
    always_comb dev_clear_seen = dev_clear & 1'b0;

    stat_event_grp #(.W(REG_W)) u_std_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (evt_pulse),
        .clr      (evt_clr | dev_clear_seen),
        .en_zero  (cmd_reset),
        .en_we    (ese_we),
        .en_wdata (bus_wdata),
        .evt_q    (evt_q),
        .en_q     (ese_q),
        .summary  (esb)
    );

    stat_rw_reg #(.W(REG_W)) u_srq_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_req (cmd_reset),
        .we       (sre_we),
        .wdata    (bus_wdata),
        .q        (sre_q)
    );

    stat_byte_build #(
        .W       (REG_W),
        .MAV_POS (MAV_BIT),
        .ESB_POS (ESB_BIT),
        .MSS_POS (MSS_BIT)
    ) u_sbyte (
        .mav    (queue_not_empty),
        .esb    (esb),
        .srq_en (sre_q),
        .sbyte  (status_byte)
    );

    stat_bus_port #(.W(REG_W), .AW(ADDR_W)) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (bus_addr),
        .rd         (bus_rd),
        .wr         (bus_wr),
        .evt_q      (evt_q),
        .evt_en_q   (ese_q),
        .sbyte      (status_byte),
        .srq_en_q   (sre_q),
        .evt_rd_clr (evt_rd_clr),
        .evt_en_we  (ese_we),
        .srq_en_we  (sre_we),
        .rdata      (bus_rdata)
    );
endmodule

// File: rtl/instr_status_chk.sv
// Property checker for instr_status_unit, attached by bind below.
module instr_status_chk
    import instr_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [REG_W-1:0]  evt_pulse,
    input logic              queue_not_empty,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_rdata,
    input logic              clr_status,
    input logic              cmd_reset,
    input logic [REG_W-1:0]  status_byte,
    input logic [REG_W-1:0]  evt_q,
    input logic [REG_W-1:0]  ese_q,
    input logic [REG_W-1:0]  sre_q
);
    logic rd_evt;
    always_comb rd_evt = bus_rd && (bus_addr == ADR_EVENT);

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_status || rd_evt) |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R1
    AST_RD_PRECLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> (bus_rdata == $past(evt_q))); // R2
    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> (evt_q == $past(evt_pulse))); // R2
    AST_CLS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_status |=> (evt_q == $past(evt_pulse))); // R3
    AST_CLS_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !cmd_reset && !bus_wr) |=> ($stable(ese_q) && $stable(sre_q))); // R3
    AST_RST_CMD_EN: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (ese_q == '0 && sre_q == '0)); // R4
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte & 8'h8F) == 8'h00); // R6
    AST_MAV_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[MAV_BIT] == queue_not_empty); // R7
    AST_ESB_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[ESB_BIT] == |(evt_q & ese_q)); // R8
    AST_MSS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[MSS_BIT] == |(status_byte & sre_q & 8'hBF)); // R9
endmodule

bind instr_status_unit instr_status_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_pulse       (evt_pulse),
    .queue_not_empty (queue_not_empty),
    .bus_addr        (bus_addr),
    .bus_rd          (bus_rd),
    .bus_wr          (bus_wr),
    .bus_rdata       (bus_rdata),
    .clr_status      (clr_status),
    .cmd_reset       (cmd_reset),
    .status_byte     (status_byte),
    .evt_q           (evt_q),
    .ese_q           (ese_q),
    .sre_q           (sre_q)
);

// File: tb/instr_status_unit_test.sv
module instr_status_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_pulse = '0;
    logic       queue_not_empty = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       clr_status = 1'b0;
    logic       cmd_reset = 1'b0;
    logic       dev_clear = 1'b0;
    logic [7:0] status_byte;

    int checks = 0;
    int failures = 0;

    // Bench model of the register state.
    logic [7:0] m_evt = '0;
    logic [7:0] m_ese = '0;
    logic [7:0] m_sre = '0;

    instr_status_unit uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_sbyte(input logic [7:0] evt, input logic [7:0] ese,
                                            input logic [7:0] sre, input logic q);
        logic [7:0] b;
        b = '0;
        b[4] = q;
        b[5] = |(evt & ese);
        b[6] = |(b & sre & 8'hBF);
        return b;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; model updated and outputs checked after the edge.
    task automatic tick(input logic [7:0] pulse, input logic rd, input logic wr,
                        input logic [1:0] addr, input logic [7:0] wd, input logic cls,
                        input logic rcmd, input logic dcl, input logic q, input string tag);
        logic [7:0] exp_rd;
        logic [7:0] sb;
        logic       clr;
        string      t;
        @(negedge clk);
        evt_pulse = pulse; bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        clr_status = cls; cmd_reset = rcmd; dev_clear = dcl; queue_not_empty = q;
        case (addr)
            2'd0: exp_rd = m_evt;
            2'd1: exp_rd = m_ese;
            2'd2: exp_rd = exp_sbyte(m_evt, m_ese, m_sre, q);
            default: exp_rd = m_sre;
        endcase
        clr = cls || (rd && addr == 2'd0);
        m_evt = (m_evt & ~{8{clr}}) | pulse;
        if (rcmd) begin m_ese = '0; m_sre = '0; end
        else if (wr && addr == 2'd1) m_ese = wd;
        else if (wr && addr == 2'd3) m_sre = wd;
        @(posedge clk);
        #1;
        if (rd) begin
            if (tag != "") t = tag;
            else if (addr == 2'd0) t = "R2 event read";
            else if (addr == 2'd2) t = "R10 status read";
            else t = "R5 enable read";
            chk(t, bus_rdata, exp_rd);
        end
        sb = exp_sbyte(m_evt, m_ese, m_sre, q);
        chk("R6 reserved bits", status_byte & 8'h8F, 8'h00);
        chk("R7 queue flag", {7'd0, status_byte[4]}, {7'd0, sb[4]});
        chk("R8 event summary", {7'd0, status_byte[5]}, {7'd0, sb[5]});
        chk("R9 master summary", {7'd0, status_byte[6]}, {7'd0, sb[6]});
        evt_pulse = '0; bus_rd = 0; bus_wr = 0; clr_status = 0; cmd_reset = 0; dev_clear = 0;
    endtask

    task automatic idle(input logic [7:0] pulse);
        tick(pulse, 0, 0, 2'd0, 8'h00, 0, 0, 0, queue_not_empty, "");
    endtask
    task automatic rd_reg(input logic [1:0] a, input logic [7:0] pulse, input string tag);
        tick(pulse, 1, 0, a, 8'h00, 0, 0, 0, queue_not_empty, tag);
    endtask
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        tick(8'h00, 0, 1, a, d, 0, 0, 0, queue_not_empty, "");
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk("R11 rdata after reset", bus_rdata, 8'h00);
        chk("R11 status after reset", status_byte, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        rd_reg(2'd0, 8'h00, "R11 event reg after reset");
        rd_reg(2'd1, 8'h00, "R11 enable reg after reset");
        rd_reg(2'd3, 8'h00, "R11 srq enable after reset");

        // R1: pulse latches and sticks after the pulse is gone
        idle(8'h05);
        idle(8'h00);
        idle(8'h00);
        rd_reg(2'd0, 8'h00, "R1 sticky event");
        rd_reg(2'd0, 8'h00, "R2 cleared after read");

        // R5: enable registers write and read back; reads keep value
        wr_reg(2'd1, 8'h04);
        rd_reg(2'd1, 8'h00, "R5 event enable readback");
        rd_reg(2'd1, 8'h00, "R5 event enable read twice");
        wr_reg(2'd3, 8'h20);
        rd_reg(2'd3, 8'h00, "R5 srq enable readback");
        idle(8'h04);                          // R8/R9 summaries rise
        rd_reg(2'd2, 8'h00, "R10 status byte read");

        // R2: read with a same-cycle pulse keeps the new pulse
        rd_reg(2'd0, 8'h80, "R2 pre-clear value");
        rd_reg(2'd0, 8'h00, "R2 pulse during read survives");

        // R3: clear-status with same-cycle pulse; enables untouched
        idle(8'h10);
        tick(8'h01, 0, 0, 2'd0, 8'h00, 1, 0, 0, 1'b0, "");
        rd_reg(2'd0, 8'h00, "R3 clear keeps same-cycle pulse");
        rd_reg(2'd1, 8'h00, "R3 enable kept");

        // R4: reset command and device clear
        wr_reg(2'd1, 8'hFF);
        idle(8'h22);
        tick(8'h00, 0, 1, 2'd1, 8'h33, 0, 1, 0, 1'b1, "");
        rd_reg(2'd1, 8'h00, "R4 reset cmd zeroes enable over write");
        rd_reg(2'd3, 8'h00, "R4 reset cmd zeroes srq enable");
        rd_reg(2'd0, 8'h00, "R4 reset cmd keeps events");
        wr_reg(2'd1, 8'h0F);
        idle(8'h09);
        tick(8'h00, 0, 0, 2'd0, 8'h00, 0, 0, 1, 1'b1, "");
        rd_reg(2'd1, 8'h00, "R4 device clear keeps enable");
        rd_reg(2'd0, 8'h00, "R4 device clear keeps events");

        // R10: writes to read-only addresses ignored
        idle(8'h41);
        wr_reg(2'd0, 8'hFF);
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd0, 8'h00, "R10 write to event ignored");
        wr_reg(2'd3, 8'hFF);                  // R9: enable bit 6 has no effect
        tick(8'h00, 0, 0, 2'd0, 8'h00, 0, 0, 0, 1'b0, "");
        tick(8'h00, 0, 0, 2'd0, 8'h00, 0, 0, 0, 1'b1, "");

        // Constrained random mix
        for (int i = 0; i < 2000; i++) begin
            logic [7:0] p;
            int         op;
            logic [1:0] a;
            p  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            op = int'($urandom_range(0, 9));
            a  = 2'($urandom);
            tick(p, op < 4, op == 4 || op == 5, a, 8'($urandom),
                 op == 6, op == 7, op == 8, 1'($urandom), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule